// File: doc/BRIEF.md
# Spinal Rateless Symbol Encoder

The block turns a 192-bit message into an open-ended stream of IQ constellation points using a spinal code. It first cuts the message into 3-bit segments. It then builds a chain of 64-bit states. Each state is a hash of the previous state and one segment, and the chain starts from a seed that the receiver also holds. The 64 finished states are kept in a small on-chip memory.

After the chain is built, the block walks over all 64 states again and again. Each walk is called a pass. For every state in a pass, it hashes the state together with the pass number and takes two signed 8-bit coordinates from the result. So every pass yields fresh points for the same message. A receiver keeps collecting points until it can decode, then tells the transmitter to stop.

Symbols leave through a valid/ready port. Each one is tagged with its spine index and pass number. A `start` pulse loads a new message and seed at any time. A `stop` pulse ends the stream after the symbol already on offer.

Top module: `spinal_encoder`

## Requirements
- R1: After reset, `out_valid` is low and stays low until the first `start`.
- R2: The hash function H(x,y) works on 64-bit words. It sets a = x and b = y XOR 0x9E3779B97F4A7C15. It then performs 4 rounds of: t = a + b (mod 2^64); b = rotl(b,13) XOR t; a = rotl(t,32). The result is a XOR b.
- R3: Spine state i, for i = 0..63, is H(previous, seg_i). Here seg_i = msg_in[3i+2:3i], zero-extended to 64 bits. The previous state for i = 0 is the seed sampled with `start`.
- R4: The symbol for spine index i on pass p is taken from h = H(state_i, p zero-extended). I is `out_iq[7:0]` = h[7:0] and Q is `out_iq[15:8]` = h[15:8], both signed two's complement.
- R5: After a `start`, symbols come out with `out_idx` running 0..63 inside a pass. `out_pass` starts at 0 and rises by one after index 63.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_iq`, `out_idx` and `out_pass` stay unchanged, unless `start` is asserted.
- R7: After `stop`, a symbol already on offer stays valid until it is accepted. No further symbol is offered until the next `start`. If no symbol was on offer when `stop` arrived, `out_valid` stays low.
- R8: `start` is honoured in any state. It drops any offered symbol, so `out_valid` is low in the next cycle, and it restarts at index 0, pass 0 with the new message and seed. When `start` and `stop` arrive in the same cycle, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load message and seed; begin a new stream |
| stop | input | 1 | End the stream after the offered symbol |
| msg_in | input | 192 | Message, segment i in bits 3i+2:3i |
| seed_in | input | 64 | Shared chain seed |
| out_ready | input | 1 | Consumer accepts the offered symbol |
| out_valid | output | 1 | A symbol is on offer |
| out_iq | output | 16 | Q in bits 15:8, I in bits 7:0 |
| out_idx | output | 6 | Spine index of the symbol |
| out_pass | output | 16 | Pass number of the symbol |

## Verification
The cases that need care are the ones where control pulses land in the same cycle as something else. The bench raises `start` and `stop` together and expects a fresh stream from index 0, pass 0 of the new message. It also asserts `stop` while a symbol is held with `out_ready` low, and expects exactly one more handshake carrying unchanged data, then silence. Finally, it issues `start` while a symbol is held and expects `out_valid` to drop on the next cycle, followed by symbols from the new spine.

// File: rtl/spn_pkg.sv
package spn_pkg;

  localparam int unsigned WORD_W = 64;
  localparam logic [WORD_W-1:0] MIX_KEY = 64'h9E3779B97F4A7C15;
  localparam int unsigned ROT_B = 13;
  localparam int unsigned ROT_A = 32;

  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
  } mix_pair_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUILD_GO,
    ST_BUILD_WAIT,
    ST_EMIT_RD,
    ST_EMIT_GO,
    ST_EMIT_WAIT,
    ST_EMIT_HOLD,
    ST_DRAIN
  } enc_state_t;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v,
                                             input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  // One add-rotate-xor round of the chain hash.
  function automatic mix_pair_t mix_round(input mix_pair_t p);
    mix_pair_t r;
    logic [WORD_W-1:0] t;
    t   = p.a + p.b;
    r.b = rotl(p.b, ROT_B) ^ t;
    r.a = rotl(t, ROT_A);
    return r;
  endfunction

endpackage

// File: rtl/spn_mixer.sv
module spn_mixer import spn_pkg::*; #(
  parameter int unsigned ROUNDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] y,
  output logic              done,
  output logic [WORD_W-1:0] result
);

  localparam int unsigned CNT_W = $clog2(ROUNDS + 1);

  mix_pair_t        pair;
  logic [CNT_W-1:0] cnt;

  // One round per cycle; done pulses in the cycle the last round is visible.
  always_ff @(posedge clk) begin
    if (rst) begin
      pair <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        pair.a <= x;
        pair.b <= y ^ MIX_KEY;
        cnt    <= CNT_W'(ROUNDS);
      end else if (cnt != '0) begin
        pair <= mix_round(pair);
        cnt  <= cnt - 1'b1;
        done <= (cnt == CNT_W'(1));
      end
    end
  end

  assign result = pair.a ^ pair.b;

endmodule

// File: rtl/spn_spine_ram.sv
module spn_spine_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spn_out_stage.sv
module spn_out_stage #(
  parameter int unsigned W = 38
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/spinal_encoder.sv
module spinal_encoder import spn_pkg::*; #(
  parameter int unsigned MSG_W   = 192,
  parameter int unsigned SEG_W   = 3,
  parameter int unsigned PASS_W  = 16,
  parameter int unsigned POINT_W = 8,
  parameter int unsigned ROUNDS  = 4,
  localparam int unsigned NSEG   = MSG_W / SEG_W,
  localparam int unsigned IDX_W  = $clog2(NSEG),
  localparam int unsigned IQ_W   = 2 * POINT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [MSG_W-1:0]  msg_in,
  input  logic [WORD_W-1:0] seed_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [IQ_W-1:0]   out_iq,
  output logic [IDX_W-1:0]  out_idx,
  output logic [PASS_W-1:0] out_pass
);

  localparam int unsigned PAY_W = IQ_W + IDX_W + PASS_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSEG - 1);

  enc_state_t        st;
  logic [MSG_W-1:0]  msg_q;
  logic [WORD_W-1:0] chain_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PASS_W-1:0] pass_q;

  logic              mix_go;
  logic [WORD_W-1:0] mix_x;
  logic [WORD_W-1:0] mix_y;
  logic              mix_done;
  logic [WORD_W-1:0] mix_res;

  logic              ram_we;
  logic [WORD_W-1:0] ram_q;

  logic              out_load;
  logic              accept;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;
  logic [SEG_W-1:0]  seg_cur;

  assign seg_cur = msg_q[idx_q*SEG_W +: SEG_W];
  assign accept  = out_valid && out_ready;

  always_comb begin
    mix_go   = 1'b0;
    mix_x    = chain_q;
    mix_y    = {{(WORD_W-SEG_W){1'b0}}, seg_cur};
    ram_we   = 1'b0;
    out_load = 1'b0;
    unique case (st)
      ST_BUILD_GO:   mix_go = !start && !stop;
      ST_BUILD_WAIT: ram_we = mix_done;
      ST_EMIT_GO: begin
        mix_go = !start && !stop;
        mix_x  = ram_q;
        mix_y  = {{(WORD_W-PASS_W){1'b0}}, pass_q};
      end
      ST_EMIT_WAIT:  out_load = mix_done && !start && !stop;
      default: ;
    endcase
  end

  assign pay_in = {mix_res[IQ_W-1:0], idx_q, pass_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      msg_q   <= '0;
      chain_q <= '0;
      idx_q   <= '0;
      pass_q  <= '0;
    end else if (start) begin
      msg_q   <= msg_in;
      chain_q <= seed_in;
      idx_q   <= '0;
      pass_q  <= '0;
      st      <= ST_BUILD_GO;
    end else if (stop && st != ST_IDLE) begin
      st <= (out_valid && !out_ready) ? ST_DRAIN : ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_BUILD_GO: st <= ST_BUILD_WAIT;
        ST_BUILD_WAIT: if (mix_done) begin
          chain_q <= mix_res;
          if (idx_q == LAST_IDX) begin
            idx_q <= '0;
            st    <= ST_EMIT_RD;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_BUILD_GO;
          end
        end
        ST_EMIT_RD:   st <= ST_EMIT_GO;
        ST_EMIT_GO:   st <= ST_EMIT_WAIT;
        ST_EMIT_WAIT: if (mix_done) st <= ST_EMIT_HOLD;
        ST_EMIT_HOLD: if (accept) begin
          if (idx_q == LAST_IDX) begin
            idx_q  <= '0;
            pass_q <= pass_q + 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
          st <= ST_EMIT_RD;
        end
        ST_DRAIN: if (accept) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  spn_mixer #(.ROUNDS(ROUNDS)) u_mix (
    .clk    (clk),
    .rst    (rst),
    .go     (mix_go),
    .x      (mix_x),
    .y      (mix_y),
    .done   (mix_done),
    .result (mix_res)
  );

  spn_spine_ram #(.DEPTH(NSEG), .DW(WORD_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (idx_q),
    .wdata (mix_res),
    .raddr (idx_q),
    .rdata (ram_q)
  );

  spn_out_stage #(.W(PAY_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .clear (start),
    .load  (out_load),
    .din   (pay_in),
    .ready (out_ready),
    .valid (out_valid),
    .dout  (pay_out)
  );

  assign out_iq   = pay_out[PAY_W-1 -: IQ_W];
  assign out_idx  = pay_out[PASS_W +: IDX_W];
  assign out_pass = pay_out[PASS_W-1:0];

endmodule

// File: rtl/spinal_encoder_chk.sv
module spinal_encoder_chk #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned PASS_W   = 16,
  parameter int unsigned IQ_W     = 16,
  parameter int unsigned LAST_IDX = 63
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              stop,
  input logic              out_ready,
  input logic              out_valid,
  input logic [IQ_W-1:0]   out_iq,
  input logic [IDX_W-1:0]  out_idx,
  input logic [PASS_W-1:0] out_pass
);

  logic              seen;
  logic [IDX_W-1:0]  last_idx;
  logic [PASS_W-1:0] last_pass;
  logic              halted;
  logic              draining;
  logic              hs;
  logic              wrap;
  logic [IDX_W-1:0]  nxt_idx;
  logic [PASS_W-1:0] nxt_pass;

  assign hs       = out_valid && out_ready;
  assign wrap     = (last_idx == IDX_W'(LAST_IDX));
  assign nxt_idx  = wrap ? '0 : last_idx + 1'b1;
  assign nxt_pass = wrap ? last_pass + 1'b1 : last_pass;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      seen      <= 1'b0;
      last_idx  <= '0;
      last_pass <= '0;
    end else if (hs) begin
      seen      <= 1'b1;
      last_idx  <= out_idx;
      last_pass <= out_pass;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      halted   <= 1'b0;
      draining <= 1'b0;
    end else if (stop) begin
      if (out_valid && !out_ready) draining <= 1'b1;
      else                         halted   <= 1'b1;
    end else if (draining && hs) begin
      draining <= 1'b0;
      halted   <= 1'b1;
    end
  end

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R5
  a_r5_first_symbol: assert property (@(posedge clk) disable iff (rst)
    (hs && !seen && !start) |-> (out_idx == '0 && out_pass == '0));

  // R5
  a_r5_sequence: assert property (@(posedge clk) disable iff (rst)
    (hs && seen && !start) |-> (out_idx == nxt_idx && out_pass == nxt_pass));

  // R6
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_iq) && $stable(out_idx) && $stable(out_pass)));

  // R7
  a_r7_quiet_after_stop: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid);

  // R7
  a_r7_drain_keeps_symbol: assert property (@(posedge clk) disable iff (rst)
    draining |-> out_valid);

  // R8
  a_r8_start_drops: assert property (@(posedge clk) disable iff (rst)
    start |=> !out_valid);

endmodule

bind spinal_encoder spinal_encoder_chk #(
  .IDX_W    (IDX_W),
  .PASS_W   (PASS_W),
  .IQ_W     (IQ_W),
  .LAST_IDX (NSEG - 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .stop      (stop),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_iq    (out_iq),
  .out_idx   (out_idx),
  .out_pass  (out_pass)
);

// File: tb/spinal_encoder_tb.sv
module spinal_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 64;
  localparam logic [63:0] KEY = 64'h9E3779B97F4A7C15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         stop = 1'b0;
  logic [191:0] msg_in = '0;
  logic [63:0]  seed_in = '0;
  logic         out_ready = 1'b0;
  logic         out_valid;
  logic [15:0]  out_iq;
  logic [5:0]   out_idx;
  logic [15:0]  out_pass;

  int n_vec = 0;
  int n_bad = 0;
  int exp_idx = 0;
  int exp_pass = 0;
  logic [63:0] ref_spine [NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  spinal_encoder u_dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .msg_in(msg_in), .seed_in(seed_in), .out_ready(out_ready),
    .out_valid(out_valid), .out_iq(out_iq), .out_idx(out_idx), .out_pass(out_pass)
  );

  function automatic logic [63:0] ref_hash(input logic [63:0] x, input logic [63:0] y);
    logic [63:0] a, b, t;
    a = x;
    b = y ^ KEY;
    for (int r = 0; r < 4; r++) begin
      t = a + b;
      b = {b[50:0], b[63:51]} ^ t;
      a = {t[31:0], t[63:32]};
    end
    return a ^ b;
  endfunction

  task automatic build_ref(input logic [191:0] m, input logic [63:0] s);
    logic [63:0] prev;
    prev = s;
    for (int i = 0; i < NSEG; i++) begin
      prev = ref_hash(prev, {61'b0, m[3*i +: 3]});
      ref_spine[i] = prev;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [191:0] m, input logic [63:0] s, input bit with_stop);
    @(negedge clk);
    msg_in = m; seed_in = s; start = 1'b1; stop = with_stop;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    build_ref(m, s);
    exp_idx = 0; exp_pass = 0;
  endtask

  task automatic stream(input int n, input int pct);
    int got = 0;
    int guard = 0;
    bit held = 0;
    logic [37:0] saved = '0;
    logic [63:0] h;
    while (got < n && guard < 30000) begin
      @(negedge clk);
      guard++;
      out_ready = (($urandom % 100) < pct);
      if (held) chk("R6 held symbol", {25'b0, out_valid, out_iq, out_idx, out_pass},
                    {25'b0, 1'b1, saved});
      if (out_valid && out_ready) begin
        h = ref_hash(ref_spine[exp_idx], {48'b0, exp_pass[15:0]});
        chk("R2 R3 R4 iq", {48'b0, out_iq}, {48'b0, h[15:0]});
        chk("R5 idx", {58'b0, out_idx}, 64'(exp_idx));
        chk("R5 pass", {48'b0, out_pass}, 64'(exp_pass));
        if (exp_idx == NSEG - 1) begin exp_idx = 0; exp_pass++; end
        else exp_idx++;
        got++;
      end
      held = out_valid && !out_ready;
      saved = {out_iq, out_idx, out_pass};
    end
    chk("R5 symbol count", 64'(got), 64'(n));
  endtask

  task automatic wait_valid();
    int guard = 0;
    while (!out_valid && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  function automatic logic [191:0] rand_msg();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [37:0] snap;
    int cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, no symbol without start
    repeat (20) begin
      @(negedge clk);
      out_ready = 1'b1;
      chk("R1 idle after reset", {63'b0, out_valid}, 64'd0);
    end

    // Directed: all-zero message and seed, crosses a pass boundary
    do_start('0, '0, 1'b0);
    stream(70, 100);
    // Directed: all-ones
    do_start({192{1'b1}}, {64{1'b1}}, 1'b0);
    stream(64, 100);
    // Random messages with random back-pressure
    for (int k = 0; k < 3; k++) begin
      do_start(rand_msg(), {$urandom, $urandom}, 1'b0);
      stream(140, 60);
    end

    // R7: stop while a symbol is held
    out_ready = 1'b0;
    wait_valid();
    snap = {out_iq, out_idx, out_pass};
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R7 held symbol survives stop", {25'b0, out_valid, out_iq, out_idx, out_pass},
        {25'b0, 1'b1, snap});
    out_ready = 1'b1;
    cnt = 0;
    repeat (80) begin
      @(negedge clk);
      if (out_valid) cnt++;
    end
    chk("R7 no symbol after drained stop", 64'(cnt), 64'd0);

    // R7: stop while spine is being built
    do_start(rand_msg(), {$urandom, $urandom}, 1'b0);
    repeat (10) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    cnt = 0;
    repeat (600) begin
      @(negedge clk);
      if (out_valid) cnt++;
    end
    chk("R7 no symbol after early stop", 64'(cnt), 64'd0);

    // R8: start and stop together, start wins
    do_start(rand_msg(), {$urandom, $urandom}, 1'b1);
    stream(20, 80);

    // R8: start while a symbol is held
    out_ready = 1'b0;
    wait_valid();
    do_start(rand_msg(), {$urandom, $urandom}, 1'b0);
    chk("R8 start drops held symbol", {63'b0, out_valid}, 64'd0);
    stream(70, 70);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule